// File: doc/BRIEF.md
# Strobed Serial Byte Transmitter

This block turns one parallel byte into an asynchronous serial frame on a single output line. A one-cycle load strobe copies the byte into a holding register. When no frame is in progress, the held byte moves into a 9-bit shift word whose lowest bit is a zero start bit. A clock divider produces one single-cycle shift enable per bit period. Each enable puts the lowest bit of the shift word on the line, so the start bit goes out first and the data follows least significant bit first. An even parity bit and a high stop bit close the frame.

A byte loaded while a frame is on the line waits in the holding register and goes out once the current stop bit has finished. The rate is set by two parameters: the system clock frequency and the bit rate, which defaults to 9600. One bit period lasts CLK_HZ/BAUD_HZ clock cycles.

Top module: `uart_strobe_tx`

## Requirements
- R1: While reset is applied, and after its release with no load, `txd_o` is 1 and `busy_o` is 0.
- R2: When `load_i` is sampled high at a clock edge while idle, `busy_o` is 1 after the next edge. One edge later the line drops to the start bit.
- R3: Every bit of a frame stays on the line for exactly CLK_HZ/BAUD_HZ clock cycles. The line changes only on a shift enable, and each enable is a single-cycle pulse.
- R4: A frame begins with one start bit of value 0, followed by the 8 data bits with bit 0 first.
- R5: The bit after the last data bit is even parity: the XOR of the 8 data bits.
- R6: After the parity bit the line is 1 for one full bit period. `busy_o` falls at the end of that period, and the line stays 1 whenever `busy_o` is 0.
- R7: A load that arrives during a frame does not change the frame in progress. Its byte is sent as the next frame, and `busy_o` is low for exactly one cycle between the two frames.
- R8: When several loads arrive during one frame, only the last byte is sent afterwards, as a single frame.
- R9: Asserting `rst_ni` low during a frame forces `txd_o` to 1 and `busy_o` to 0 at once, and discards any byte waiting to be sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load_i | input | 1 | Load strobe; captures `data_i` on the clock edge where it is high |
| data_i | input | DATA_W (8) | Parallel byte to be sent |
| txd_o | output | 1 | Serial line, idles high |
| busy_o | output | 1 | High while a frame occupies the line, through the end of the stop bit |

## Verification
The hardest condition to reach is a byte waiting in the holding register while another frame is still being shifted out. The stimulus raises the load strobe in the middle of chosen bits of a running frame, once or twice with different bytes. The bench then checks that the running frame keeps its bits, and that exactly one further frame follows carrying the last of those bytes after a single idle cycle. A reset applied in the middle of a start bit, with a byte queued, shows whether the queued byte is really discarded.

// File: rtl/tx_pkg.sv
package tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DATA = 3'd1,
    ST_PAR  = 3'd2,
    ST_STOP = 3'd3,
    ST_END  = 3'd4
  } tx_state_e;
endpackage

// File: rtl/tx_rst_sync.sv
module tx_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1] & rst_ni;
endmodule

// File: rtl/tx_baud_div.sv
module tx_baud_div #(
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned BAUD_HZ = 9600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned DIV_TC = (CLK_HZ / BAUD_HZ) - 1;
  localparam int unsigned CNT_W  = (DIV_TC < 1) ? 1 : $clog2(DIV_TC + 1);
  localparam logic [CNT_W-1:0] TC = CNT_W'(DIV_TC);

  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    if (restart_i)        cnt_n = TC;
    else if (!en_i)       cnt_n = '0;
    else if (cnt_q == TC) cnt_n = '0;
    else                  cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_n;
  end

  assign tick_o = en_i && (cnt_q == TC);

  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TC);

  generate
    if (DIV_TC > 0) begin : g_pulse_chk
      a_r3_tick_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/tx_hold_stage.sv
module tx_hold_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         take_i,
  output logic [W-1:0] hold_o,
  output logic         pend_o
);
  logic [W-1:0] hold_q, hold_n;
  logic         pend_q, pend_n;

  always_comb begin
    hold_n = hold_q;
    pend_n = pend_q;
    if (load_i) begin
      hold_n = data_i;
      pend_n = 1'b1;
    end else if (take_i) begin
      pend_n = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      pend_q <= 1'b0;
    end else begin
      hold_q <= hold_n;
      pend_q <= pend_n;
    end
  end

  assign hold_o = hold_q;
  assign pend_o = pend_q;

  a_r7_pend_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !take_i) |=> pend_q);
endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
  import tx_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         pend_i,
  input  logic [W-1:0] hold_i,
  output logic         take_o,
  output logic         active_o,
  output logic         txd_o
);
  localparam int unsigned SH_W  = W + 1;
  localparam int unsigned BIT_W = $clog2(SH_W + 1);
  localparam logic [BIT_W-1:0] LAST_SHIFT = BIT_W'(W);

  tx_state_e        st_q, st_n;
  logic [SH_W-1:0]  sh_q, sh_n;
  logic [BIT_W-1:0] bit_q, bit_n;
  logic             par_q, par_n;
  logic             txd_q, txd_n;

  assign take_o = (st_q == ST_IDLE) && pend_i;

  always_comb begin
    st_n  = st_q;
    sh_n  = sh_q;
    bit_n = bit_q;
    par_n = par_q;
    txd_n = txd_q;
    unique case (st_q)
      ST_IDLE: begin
        txd_n = 1'b1;
        if (pend_i) begin
          sh_n  = {hold_i, 1'b0};
          par_n = ^hold_i;
          bit_n = '0;
          st_n  = ST_DATA;
        end
      end
      ST_DATA: begin
        if (tick_i) begin
          txd_n = sh_q[0];
          sh_n  = sh_q >> 1;
          bit_n = bit_q + 1'b1;
          if (bit_q == LAST_SHIFT) st_n = ST_PAR;
        end
      end
      ST_PAR: begin
        if (tick_i) begin
          txd_n = par_q;
          st_n  = ST_STOP;
        end
      end
      ST_STOP: begin
        if (tick_i) begin
          txd_n = 1'b1;
          st_n  = ST_END;
        end
      end
      ST_END: begin
        if (tick_i) st_n = ST_IDLE;
      end
      default: begin
        st_n  = ST_IDLE;
        txd_n = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      sh_q  <= '0;
      bit_q <= '0;
      par_q <= 1'b0;
      txd_q <= 1'b1;
    end else begin
      st_q  <= st_n;
      sh_q  <= sh_n;
      bit_q <= bit_n;
      par_q <= par_n;
      txd_q <= txd_n;
    end
  end

  assign active_o = (st_q != ST_IDLE);
  assign txd_o    = txd_q;

  a_r2_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> (st_q == ST_DATA));

  a_r3_line_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(txd_q));

  a_r4_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DATA && bit_q == '0 && tick_i) |=> !txd_q);

  a_r6_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> txd_q);
endmodule

// File: rtl/uart_strobe_tx.sv
module uart_strobe_tx #(
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned BAUD_HZ = 9600,
  parameter int unsigned DATA_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              txd_o,
  output logic              busy_o
);
  logic              rst_n_int;
  logic              tick_w;
  logic              take_w;
  logic              active_w;
  logic              pend_w;
  logic [DATA_W-1:0] hold_w;

  tx_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_int)
  );

  tx_baud_div #(.CLK_HZ(CLK_HZ), .BAUD_HZ(BAUD_HZ)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .en_i      (active_w),
    .restart_i (take_w),
    .tick_o    (tick_w)
  );

  tx_hold_stage #(.W(DATA_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .load_i (load_i),
    .data_i (data_i),
    .take_i (take_w),
    .hold_o (hold_w),
    .pend_o (pend_w)
  );

  tx_frame_seq #(.W(DATA_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .tick_i   (tick_w),
    .pend_i   (pend_w),
    .hold_i   (hold_w),
    .take_o   (take_w),
    .active_o (active_w),
    .txd_o    (txd_o)
  );

  assign busy_o = active_w;

  a_r7_queued: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (busy_o && load_i) |=> pend_w);

  a_r6_line_idle: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !busy_o |-> txd_o);
endmodule

// File: tb/sim_uart_strobe_tx.sv
`timescale 1ns/1ps
module sim_uart_strobe_tx;
  localparam int unsigned CLK_HZ  = 96000;
  localparam int unsigned BAUD_HZ = 9600;
  localparam int N = CLK_HZ / BAUD_HZ;
  localparam int NVEC = 6;
  localparam logic [7:0] VEC [NVEC] = '{8'h00, 8'hFF, 8'hA5, 8'h01, 8'h80, 8'h6E};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [7:0] data = 8'h00;
  logic       txd, busy;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_strobe_tx #(.CLK_HZ(CLK_HZ), .BAUD_HZ(BAUD_HZ), .DATA_W(8)) u0 (
    .clk_i (clk), .rst_ni (rst_n), .load_i (load), .data_i (data),
    .txd_o (txd), .busy_o (busy)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic strobe(input logic [7:0] b);
    @(negedge clk);
    load = 1'b1; data = b;
    @(posedge clk);
    #1 load = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic exp_bit(input logic [7:0] b, input int k);
    if (k == 0) return 1'b0;
    if (k <= 8) return b[k-1];
    if (k == 9) return ^b;
    return 1'b1;
  endfunction

  function automatic string bit_tag(input int k);
    if (k <= 8) return "R4";
    if (k == 9) return "R5";
    return "R6";
  endfunction

  task automatic frame_check(input logic [7:0] b, input string start_tag,
                             input int ia, input logic [7:0] va,
                             input int ib, input logic [7:0] vb);
    int waits = 0;
    while (!busy && waits < 4 * N) begin
      @(negedge clk);
      waits++;
    end
    chk(start_tag, "cycles from strobe to busy", waits, 1);
    @(posedge clk);
    for (int k = 0; k < 11; k++) begin
      @(negedge clk);
      chk("R3", $sformatf("first cycle of bit %0d", k), txd, exp_bit(b, k));
      if (k == ia || k == ib) begin
        load = 1'b1;
        data = (k == ia) ? va : vb;
        @(posedge clk);
        #1 load = 1'b0;
        repeat (N - 2) @(posedge clk);
      end else begin
        repeat (N - 1) @(posedge clk);
      end
      @(negedge clk);
      chk(bit_tag(k), $sformatf("last cycle of bit %0d", k), txd, exp_bit(b, k));
      chk("R2", $sformatf("busy during bit %0d", k), busy, 1);
      @(posedge clk);
    end
    @(negedge clk);
    chk("R6", "busy after stop bit", busy, 0);
    chk("R6", "line after stop bit", txd, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "line in reset", txd, 1);
    chk("R1", "busy in reset", busy, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1", "line after reset", txd, 1);
    chk("R1", "busy after reset", busy, 0);

    for (int i = 0; i < NVEC; i++) begin
      strobe(VEC[i]);
      frame_check(VEC[i], "R2", -1, 8'h00, -1, 8'h00);
    end

    // R7: one load mid-frame, sent next
    strobe(8'h3C);
    frame_check(8'h3C, "R2", 4, 8'hC9, -1, 8'h00);
    frame_check(8'hC9, "R7", -1, 8'h00, -1, 8'h00);
    repeat (3 * N) @(negedge clk);
    chk("R7", "no extra frame", busy, 0);

    // R8: two loads mid-frame, last wins, single frame
    strobe(8'h0F);
    frame_check(8'h0F, "R2", 2, 8'h11, 7, 8'hE4);
    frame_check(8'hE4, "R8", -1, 8'h00, -1, 8'h00);
    repeat (3 * N) @(negedge clk);
    chk("R8", "single queued frame", busy, 0);
    chk("R8", "line idle", txd, 1);

    // R9: reset mid start bit with a byte queued
    strobe(8'h00);
    while (!busy) @(negedge clk);
    @(posedge clk);
    #1 load = 1'b1; data = 8'h55;
    @(posedge clk);
    #1 load = 1'b0;
    @(negedge clk);
    chk("R4", "start bit before reset", txd, 0);
    rst_n = 1'b0;
    #0.5;
    chk("R9", "line at reset", txd, 1);
    chk("R9", "busy at reset", busy, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4 * N) @(negedge clk);
    chk("R9", "queued byte discarded", busy, 0);
    chk("R9", "line after reset", txd, 1);

    strobe(8'h96);
    frame_check(8'h96, "R2", -1, 8'h00, -1, 8'h00);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule